// File: doc/BRIEF.md
# Stereo Audio Codec Serial Link

This block connects a system-clock-domain audio datapath to an external stereo codec over a four-wire serial link. It divides the system clock to produce the codec's master clock, its bit clock and its channel-select clock. It shifts one stereo playback pair out on the codec's serial input line and assembles one stereo capture pair from the codec's serial output line in every sample frame. Both directions use 20-bit samples.

The parallel side has one point of contact per frame. A single-cycle transfer strobe marks the moment the freshly captured left and right words appear on the outputs. On that same cycle the block takes in the left and right words it will play back during the next frame. A client that reacts to the strobe therefore moves one captured pair and one playback pair per frame. All ratios are fixed: master clock at 256, bit clock at 64 and channel select at 1 times the frame rate. A parameter sets how many system clocks make one master clock period.

Top module: `stereo_codec_link`

## Requirements
- R1: With 2^MCLK_LOG2 system clocks per master clock period, the bit clock period is four master clock periods. A frame is 64 bit clocks, and the channel select changes every 32 bit clocks. Every bit clock transition falls on a master clock falling transition.
- R2: The channel select is 1 while the left half-frame is on the line and 0 during the right half. The channel select and the serial output change only where the bit clock falls.
- R3: Each half-frame carries its 20-bit word MSB first in its first 20 bit periods. The remaining 12 bit periods of each half are driven 0.
- R4: Serial capture takes the codec data level present at the rising bit clock edge. That level must have been stable for at least two system clocks, because of a two-stage synchronizer. Levels in the 12 padding periods of each half have no effect on the captured words.
- R5: The transfer strobe is high for exactly one system clock per frame. That clock is the one right after the bit clock rises for the last (20th) right-channel bit, so the channel select is 0 and the bit clock is 1 in that cycle.
- R6: In the strobe cycle the capture outputs hold the left and right words received in the frame that is ending. They keep these values until the next strobe.
- R7: The playback inputs are sampled only at the clock edge that ends the strobe cycle. The sampled pair is sent in the following frame, and the inputs have no effect at any other time.
- R8: In reset and right after it, the capture outputs, the strobe, the serial output and the bit clock are 0, and the channel select is 1. The frame that starts at reset is discarded. The first strobe comes at the end of the second frame, and the serial output sends zero words until the first latched pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| codec_mclk_o | output | 1 | Master clock to the codec |
| codec_bclk_o | output | 1 | Bit-shift clock to the codec |
| codec_lrsel_o | output | 1 | Channel select, 1 = left |
| codec_din_o | output | 1 | Serial playback data to the codec |
| codec_dout_i | input | 1 | Serial capture data from the codec |
| xfer_o | output | 1 | One-cycle frame transfer strobe |
| cap_left_o | output | 20 | Captured left sample |
| cap_right_o | output | 20 | Captured right sample |
| play_left_i | input | 20 | Left playback sample, taken at the strobe |
| play_right_i | input | 20 | Right playback sample, taken at the strobe |

## Verification
The hardest case to reach from the ports is the exchange at the frame boundary. The last right-channel bit must land in the capture word in the very cycle the strobe rises, while the playback pair taken on that strobe must not leak into the half-frame still on the line. The bench drives the serial input from a codec model that follows the bit clock edges and fills the padding periods with ones. It holds the playback inputs at garbage values except in a window before each strobe. Every word it receives on the serial output must then match the pair offered before the previous strobe.

// File: rtl/codec_link_pkg.sv
package codec_link_pkg;

  localparam int SLOT_LEN   = 32;
  localparam int SLOT_IDX_W = 5;
  localparam int MCLK_PER_BCLK_LOG2 = 2;

  typedef enum logic {
    SLOT_LEFT  = 1'b0,
    SLOT_RIGHT = 1'b1
  } slot_e;

  typedef struct packed {
    slot_e                 slot;
    logic [SLOT_IDX_W-1:0] idx;
  } frame_pos_t;

  // True when the bit position carries sample data rather than padding.
  function automatic logic is_data_bit(frame_pos_t p, int sample_w);
    return int'(p.idx) < sample_w;
  endfunction

  // Bit number inside the sample word for an MSB-first position.
  function automatic int word_bit(frame_pos_t p, int sample_w);
    return sample_w - 1 - int'(p.idx);
  endfunction

  // True when the position is the final data bit of the right half.
  function automatic logic is_frame_last(frame_pos_t p, int sample_w);
    return (p.slot == SLOT_RIGHT) && (int'(p.idx) == sample_w - 1);
  endfunction

endpackage

// File: rtl/codec_clk_gen.sv
module codec_clk_gen
  import codec_link_pkg::*;
#(
  parameter int MCLK_LOG2 = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       mclk_o,
  output logic       bclk_o,
  output logic       lrsel_o,
  output logic       rise_en_o,
  output logic       fall_en_o,
  output logic       primed_o,
  output frame_pos_t pos_o,
  output frame_pos_t pos_next_o
);

  localparam int BCLK_LOG2 = MCLK_LOG2 + MCLK_PER_BCLK_LOG2;
  localparam int POS_W     = $bits(frame_pos_t);
  localparam int CNT_W     = BCLK_LOG2 + POS_W;
  localparam logic [BCLK_LOG2-1:0] RISE_PHASE = {1'b0, {(BCLK_LOG2-1){1'b1}}};
  localparam logic [BCLK_LOG2-1:0] FALL_PHASE = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             primed_q;

  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (&cnt_q) primed_q <= 1'b1;
    end
  end

  assign mclk_o     = cnt_q[MCLK_LOG2-1];
  assign bclk_o     = cnt_q[BCLK_LOG2-1];
  assign pos_o      = frame_pos_t'(cnt_q[CNT_W-1 -: POS_W]);
  assign pos_next_o = frame_pos_t'(cnt_nxt[CNT_W-1 -: POS_W]);
  assign lrsel_o    = (pos_o.slot == SLOT_LEFT);
  assign rise_en_o  = (cnt_q[BCLK_LOG2-1:0] == RISE_PHASE);
  assign fall_en_o  = (cnt_q[BCLK_LOG2-1:0] == FALL_PHASE);
  assign primed_o   = primed_q;

endmodule

// File: rtl/codec_rx.sv
module codec_rx
  import codec_link_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sdata_i,
  input  logic                rise_en_i,
  input  logic                primed_i,
  input  frame_pos_t          pos_i,
  output logic                xfer_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);

  localparam logic [SAMPLE_W-1:0] ONE = {{(SAMPLE_W-1){1'b0}}, 1'b1};

  function automatic logic [SAMPLE_W-1:0] put_bit(
    input logic [SAMPLE_W-1:0] w, input int bitn, input logic b);
    logic [SAMPLE_W-1:0] m;
    m = ONE << bitn;
    return b ? (w | m) : (w & ~m);
  endfunction

  logic [1:0]          sync_q;
  logic [SAMPLE_W-1:0] shl_q, shr_q, shl_nxt, shr_nxt;
  logic                take, frame_last, deliver;

  always_comb begin
    take       = rise_en_i && is_data_bit(pos_i, SAMPLE_W);
    frame_last = rise_en_i && is_frame_last(pos_i, SAMPLE_W);
    deliver    = frame_last && primed_i;
    shl_nxt    = shl_q;
    shr_nxt    = shr_q;
    if (take && pos_i.slot == SLOT_LEFT)
      shl_nxt = put_bit(shl_q, word_bit(pos_i, SAMPLE_W), sync_q[1]);
    if (take && pos_i.slot == SLOT_RIGHT)
      shr_nxt = put_bit(shr_q, word_bit(pos_i, SAMPLE_W), sync_q[1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      shl_q   <= '0;
      shr_q   <= '0;
      xfer_o  <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      sync_q <= {sync_q[0], sdata_i};
      shl_q  <= shl_nxt;
      shr_q  <= shr_nxt;
      xfer_o <= deliver;
      if (deliver) begin
        left_o  <= shl_nxt;
        right_o <= shr_nxt;
      end
    end
  end

endmodule

// File: rtl/codec_tx.sv
module codec_tx
  import codec_link_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall_en_i,
  input  logic                load_i,
  input  frame_pos_t          pos_next_i,
  input  logic [SAMPLE_W-1:0] play_left_i,
  input  logic [SAMPLE_W-1:0] play_right_i,
  output logic                sdata_o
);

  function automatic logic pick_bit(
    input logic [SAMPLE_W-1:0] l, input logic [SAMPLE_W-1:0] r,
    input frame_pos_t p);
    logic [SAMPLE_W-1:0] w;
    if (!is_data_bit(p, SAMPLE_W)) return 1'b0;
    w = (p.slot == SLOT_LEFT) ? l : r;
    w = w >> word_bit(p, SAMPLE_W);
    return w[0];
  endfunction

  logic [SAMPLE_W-1:0] hold_l_q, hold_r_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      sdata_o  <= 1'b0;
    end else begin
      if (load_i) begin
        hold_l_q <= play_left_i;
        hold_r_q <= play_right_i;
      end
      if (fall_en_i) sdata_o <= pick_bit(hold_l_q, hold_r_q, pos_next_i);
    end
  end

endmodule

// File: rtl/stereo_codec_link.sv
module stereo_codec_link
  import codec_link_pkg::*;
#(
  parameter int SAMPLE_W  = 20,
  parameter int MCLK_LOG2 = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                codec_mclk_o,
  output logic                codec_bclk_o,
  output logic                codec_lrsel_o,
  output logic                codec_din_o,
  input  logic                codec_dout_i,
  output logic                xfer_o,
  output logic [SAMPLE_W-1:0] cap_left_o,
  output logic [SAMPLE_W-1:0] cap_right_o,
  input  logic [SAMPLE_W-1:0] play_left_i,
  input  logic [SAMPLE_W-1:0] play_right_i
);

  logic       rise_en_w, fall_en_w, primed_w;
  frame_pos_t pos_w, pos_next_w;
  logic [SLOT_IDX_W-1:0] line_idx_w;

  assign line_idx_w = pos_w.idx;

  codec_clk_gen #(.MCLK_LOG2(MCLK_LOG2)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclk_o    (codec_mclk_o),
    .bclk_o    (codec_bclk_o),
    .lrsel_o   (codec_lrsel_o),
    .rise_en_o (rise_en_w),
    .fall_en_o (fall_en_w),
    .primed_o  (primed_w),
    .pos_o     (pos_w),
    .pos_next_o(pos_next_w)
  );

  codec_rx #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdata_i  (codec_dout_i),
    .rise_en_i(rise_en_w),
    .primed_i (primed_w),
    .pos_i    (pos_w),
    .xfer_o   (xfer_o),
    .left_o   (cap_left_o),
    .right_o  (cap_right_o)
  );

  codec_tx #(.SAMPLE_W(SAMPLE_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_en_i   (fall_en_w),
    .load_i      (xfer_o),
    .pos_next_i  (pos_next_w),
    .play_left_i (play_left_i),
    .play_right_i(play_right_i),
    .sdata_o     (codec_din_o)
  );

endmodule

// File: rtl/stereo_codec_link_chk.sv
module stereo_codec_link_chk #(
  parameter int SAMPLE_W = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mclk,
  input logic                bclk,
  input logic                lrsel,
  input logic                din,
  input logic                xfer,
  input logic [SAMPLE_W-1:0] cap_left,
  input logic [SAMPLE_W-1:0] cap_right,
  input logic                primed,
  input logic [4:0]          line_idx
);

  p_bclk_on_mclk_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bclk) |-> $fell(mclk))
    else $error("R1 bit clock moved off a master clock fall");

  p_lrsel_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrsel) |-> $fell(bclk))
    else $error("R2 channel select moved off a bit clock fall");

  p_din_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(din) |-> $fell(bclk))
    else $error("R2 serial output moved off a bit clock fall");

  p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(line_idx) >= SAMPLE_W) |-> !din)
    else $error("R3 padding bit not zero");

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !xfer)
    else $error("R5 strobe longer than one cycle");

  p_strobe_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (!lrsel && bclk))
    else $error("R5 strobe outside the right half with bit clock high");

  p_cap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cap_left) || !$stable(cap_right)) |-> xfer)
    else $error("R6 capture outputs changed without a strobe");

  p_no_early_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !xfer)
    else $error("R8 strobe during the discarded first frame");

endmodule

bind stereo_codec_link stereo_codec_link_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mclk     (codec_mclk_o),
  .bclk     (codec_bclk_o),
  .lrsel    (codec_lrsel_o),
  .din      (codec_din_o),
  .xfer     (xfer_o),
  .cap_left (cap_left_o),
  .cap_right(cap_right_o),
  .primed   (primed_w),
  .line_idx (line_idx_w)
);

// File: tb/stereo_codec_link_bench.sv
`timescale 1ns/1ps
module stereo_codec_link_bench;

  localparam int SAMPLE_W   = 20;
  localparam int MCLK_LOG2  = 1;
  localparam int MCLK_CYC   = 1 << MCLK_LOG2;
  localparam int BCLK_CYC   = MCLK_CYC * 4;
  localparam int FRAME_CYC  = BCLK_CYC * 64;
  localparam int FIRST_XFER = FRAME_CYC + FRAME_CYC/2 + (SAMPLE_W-1)*BCLK_CYC + BCLK_CYC/2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk, bclk, lrsel, din, xfer;
  logic sdto = 1'b0;
  logic [SAMPLE_W-1:0] cap_l, cap_r, play_l, play_r;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  stereo_codec_link #(.SAMPLE_W(SAMPLE_W), .MCLK_LOG2(MCLK_LOG2)) u_stereo_codec_link (
    .clk(clk), .rst_n(rst_n),
    .codec_mclk_o(mclk), .codec_bclk_o(bclk), .codec_lrsel_o(lrsel),
    .codec_din_o(din), .codec_dout_i(sdto), .xfer_o(xfer),
    .cap_left_o(cap_l), .cap_right_o(cap_r),
    .play_left_i(play_l), .play_right_i(play_r)
  );

  function automatic logic [SAMPLE_W-1:0] src_l(int f);
    case (f)
      2: return 20'hFFFFF;
      3: return 20'h80000;
      default: return 20'((f * 32'h2C9A7) ^ 32'h5A5A5);
    endcase
  endfunction
  function automatic logic [SAMPLE_W-1:0] src_r(int f);
    case (f)
      2: return 20'h00000;
      3: return 20'h00001;
      default: return 20'((f * 32'h71F3) + 32'h3C3C);
    endcase
  endfunction
  function automatic logic [SAMPLE_W-1:0] ply_l(int f);
    if (f < 2) return '0;
    if (f == 4) return 20'hFFFFF;
    return 20'((f * 32'h1D2B3) ^ 32'hA0F0F);
  endfunction
  function automatic logic [SAMPLE_W-1:0] ply_r(int f);
    if (f < 2) return '0;
    if (f == 4) return 20'h80001;
    return 20'((f * 32'h3E71) ^ 32'h0C3A5);
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  // codec model: drives capture data on bit clock falls, reads playback on rises
  logic prev_b, prev_lr;
  int   idx, slot, fc, pad_err;
  logic [SAMPLE_W-1:0] rx_l, rx_r;
  logic [SAMPLE_W-1:0] got_l [0:15];
  logic [SAMPLE_W-1:0] got_r [0:15];

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_b = 1'b0; prev_lr = 1'b1; idx = 0; slot = 0; fc = 0; pad_err = 0;
      rx_l = '0; rx_r = '0;
    end else begin
      if (prev_b && !bclk) begin
        if (lrsel != prev_lr) begin
          idx = 0;
          slot = lrsel ? 0 : 1;
          if (lrsel) fc++;
        end else idx++;
        if (idx < SAMPLE_W)
          sdto = (slot == 0) ? src_l(fc)[SAMPLE_W-1-idx] : src_r(fc)[SAMPLE_W-1-idx];
        else
          sdto = 1'b1;
      end
      if (!prev_b && bclk) begin
        if (idx < SAMPLE_W) begin
          if (slot == 0) rx_l[SAMPLE_W-1-idx] = din;
          else rx_r[SAMPLE_W-1-idx] = din;
        end else if (din) pad_err++;
        if (slot == 1 && idx == SAMPLE_W-1) begin
          got_l[fc & 15] = rx_l;
          got_r[fc & 15] = rx_r;
        end
      end
      prev_b = bclk;
      prev_lr = lrsel;
    end
  end

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(cap_l == '0 && cap_r == '0, "R8", "capture in reset", {cap_l[15:0], cap_r[15:0]}, 0);
    chk(xfer == 1'b0 && din == 1'b0, "R8", "strobe/din in reset", {xfer, din}, 0);
    chk(lrsel == 1'b1 && bclk == 1'b0, "R8", "lrsel/bclk in reset", {lrsel, bclk}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cap_l == '0 && xfer == 1'b0 && lrsel == 1'b1, "R8", "state after release",
        {cap_l[15:0], xfer, lrsel}, 1);
  endtask

  task automatic t_clock_ratios();
    int m0, m1, b0, b1, lf, lr;
    logic pm, pb, pl;
    logic early;
    m0 = -1; m1 = -1; b0 = -1; b1 = -1; lf = -1; lr = -1;
    pm = mclk; pb = bclk; pl = lrsel; early = 1'b0;
    while (lr < 0) begin
      @(negedge clk);
      if (xfer) early = 1'b1;
      if (!pm && mclk) begin if (m0 < 0) m0 = cyc; else if (m1 < 0) m1 = cyc; end
      if (!pb && bclk) begin if (b0 < 0) b0 = cyc; else if (b1 < 0) b1 = cyc; end
      if (pl && !lrsel && lf < 0) lf = cyc;
      if (!pl && lrsel) lr = cyc;
      pm = mclk; pb = bclk; pl = lrsel;
    end
    chk(m1 - m0 == MCLK_CYC, "R1", "master clock period", m1 - m0, MCLK_CYC);
    chk(b1 - b0 == BCLK_CYC, "R1", "bit clock period", b1 - b0, BCLK_CYC);
    chk(lf == FRAME_CYC/2, "R1", "channel select first fall", lf, FRAME_CYC/2);
    chk(lr == FRAME_CYC, "R1", "frame length", lr, FRAME_CYC);
    chk(!early, "R8", "no strobe in first frame", early, 0);
  endtask

  task automatic wait_xfer();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!xfer && guard < 2*FRAME_CYC);
  endtask

  task automatic handle_xfer();
    int f;
    f = fc;
    chk(xfer == 1'b1, "R5", "strobe seen", xfer, 1);
    chk(lrsel == 1'b0 && bclk == 1'b1, "R5", "strobe slot", {lrsel, bclk}, 1);
    chk(cap_l == src_l(f), "R6", "captured left", cap_l, src_l(f));
    chk(cap_r == src_r(f), "R4", "captured right, padding ignored", cap_r, src_r(f));
    @(negedge clk);
    chk(xfer == 1'b0, "R5", "strobe one cycle", xfer, 0);
    chk(got_l[f & 15] == ply_l(f), (f < 2) ? "R8" : "R7", "left word on line", got_l[f & 15], ply_l(f));
    chk(got_r[f & 15] == ply_r(f), (f < 2) ? "R8" : "R2", "right word on line", got_r[f & 15], ply_r(f));
    play_l = ~ply_l(f + 1) ^ 20'h13579;
    play_r = ~ply_r(f + 1) ^ 20'h2468A;
    while (!lrsel) @(negedge clk);
    chk(cap_l == src_l(f) && cap_r == src_r(f), "R6", "capture held", cap_l, src_l(f));
    while (lrsel) @(negedge clk);
    play_l = ply_l(f + 2);
    play_r = ply_r(f + 2);
  endtask

  task automatic t_first_strobe();
    wait_xfer();
    chk(cyc == FIRST_XFER, "R8", "first strobe cycle", cyc, FIRST_XFER);
    chk(fc == 1, "R5", "first strobe frame", fc, 1);
    chk(got_l[0] == '0 && got_r[0] == '0, "R8", "zero words after reset", got_l[0], 0);
    handle_xfer();
  endtask

  task automatic t_stream(input int n);
    for (int k = 0; k < n; k++) begin
      wait_xfer();
      handle_xfer();
    end
  endtask

  task automatic t_padding();
    chk(pad_err == 0, "R3", "padding periods all zero", pad_err, 0);
  endtask

  initial begin
    play_l = ply_l(2);
    play_r = ply_r(2);
    t_reset_state();
    t_clock_ratios();
    t_first_strobe();
    t_stream(7);
    t_padding();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule